// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block turns already-digitized supply-monitor flags and a pushbutton input into a clean active-low processor reset. Reset is held low while the supply is under its threshold, while the system runs from its backup source, or while the manual reset line is pulled low. Once every such condition has gone away, a hold timer keeps reset low for one full pulse interval and then releases it. Any new disturbance during that interval clears the timer, so the interval is always measured from the end of the last disturbance.

The manual input is asynchronous. It is brought into the clock domain through two flip-flops. The pulse interval is long enough to ride out pushbutton bounce, so there is no separate debouncer. The pulse width is given in clock cycles by a parameter, and the counter is sized from that parameter.

Top module: `sup_reset_gen`

## Requirements
- R1: While `rst` is high the output `cpu_rst_n` is low from the next edge onward. After `rst` falls, with all other inputs quiet, `cpu_rst_n` rises on the HOLD_CYCLES-th rising edge at which `rst` is sampled low.
- R2: A high level on `vdd_low` drives `cpu_rst_n` low from the next rising edge, and `cpu_rst_n` stays low for as long as `vdd_low` is sampled high.
- R3: After `vdd_low` clears, `cpu_rst_n` rises on the HOLD_CYCLES-th rising edge that samples it low, provided no other disturbance occurs.
- R4: If `vdd_low` goes high again while a hold interval is running, the timer restarts. Release then comes HOLD_CYCLES edges after the flag clears for the last time.
- R5: `btn_rst_n` passes through a two-flop synchronizer. A low level drives `cpu_rst_n` low on the third rising edge that samples it. After it returns high, `cpu_rst_n` rises on edge HOLD_CYCLES+2, where the first edge that samples it high is edge 1.
- R6: While `on_battery` is high, `cpu_rst_n` is low from the next rising edge onward.
- R7: A manual press that happens entirely inside backup mode does not extend the reset. If `btn_rst_n` is high for at least two edges before `on_battery` falls, release comes HOLD_CYCLES edges after backup exit.
- R8: A bouncing manual input (several short lows, each as short as one cycle) gives a single reset that ends HOLD_CYCLES+2 edges after the last rising bounce.
- R9: Once released with all inputs quiet, `cpu_rst_n` stays high indefinitely. The counter saturates and does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| vdd_low | input | 1 | Supply below reset threshold (synchronous flag) |
| btn_rst_n | input | 1 | Raw asynchronous manual reset, active low |
| on_battery | input | 1 | Backup-power mode flag (synchronous) |
| cpu_rst_n | output | 1 | Processor reset, active low |

## Verification
The bench builds the block with HOLD_CYCLES set to 8. This makes every release edge, restart and saturation reachable within a few dozen cycles, so the output is compared on every cycle rather than only at chosen points. An 8-cycle interval is short enough to place a brownout in the middle of a running pulse and to bounce the button several times inside a single interval. It is also long enough to show that the counter holds at its limit instead of wrapping during a long quiet stretch.

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
  parameter int HOLD_CYCLES = 10_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic vdd_low,
  input  logic btn_rst_n,
  input  logic on_battery,
  output logic cpu_rst_n
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);

  logic          btn_m, btn_s;
  logic [CW-1:0] quiet;
  logic          disturb;

  always_ff @(posedge clk) begin
    if (rst) begin
      btn_m <= 1'b1;
      btn_s <= 1'b1;
    end else begin
      btn_m <= btn_rst_n;
      btn_s <= btn_m;
    end
  end

  assign disturb = vdd_low | on_battery | (~btn_s & ~on_battery);

  always_ff @(posedge clk) begin
    if (rst || disturb)
      quiet <= '0;
    else if (quiet != LIMIT)
      quiet <= quiet + 1'b1;
  end

  assign cpu_rst_n = (quiet == LIMIT);

  AST_RESET_HOLDS_LOW: assert property (@(posedge clk) rst |=> !cpu_rst_n); // R1
  AST_SUPPLY_LOW: assert property (@(posedge clk) disable iff (rst) vdd_low |=> !cpu_rst_n); // R2
  AST_BACKUP_LOW: assert property (@(posedge clk) disable iff (rst) on_battery |=> !cpu_rst_n); // R6
  AST_BUTTON_LOW: assert property (@(posedge clk) disable iff (rst) !btn_s |=> !cpu_rst_n); // R5
  AST_STAYS_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (cpu_rst_n && !vdd_low && !on_battery && btn_s) |=> cpu_rst_n); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) quiet <= LIMIT); // R9
endmodule

// File: tb/sim_sup_reset_gen.sv
module sim_sup_reset_gen;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst = 1'b1, vdd_low = 1'b0, btn_rst_n = 1'b1, on_battery = 1'b0;
  logic cpu_rst_n;

  always #10 clk = ~clk;

  sup_reset_gen #(.HOLD_CYCLES(H)) u0 (
    .clk(clk), .rst(rst), .vdd_low(vdd_low), .btn_rst_n(btn_rst_n),
    .on_battery(on_battery), .cpu_rst_n(cpu_rst_n)
  );

  typedef struct { logic exp; string req; } item_t;
  item_t sb[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int   m_q;
  logic m_b1 = 1'b1, m_b2 = 1'b1;

  // Predict the output after the coming edge from the stated timing rules.
  task automatic drive(input logic r, input logic s, input logic b,
                       input logic bk, input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #2;
      rst = r; vdd_low = s; btn_rst_n = b; on_battery = bk;
      if (r) begin
        m_q = 0; m_b1 = 1'b1; m_b2 = 1'b1;
      end else begin
        if (s || bk || !m_b2) m_q = 0;
        else if (m_q < H) m_q++;
        m_b2 = m_b1; m_b1 = b;
      end
      sb.push_back('{exp: (m_q == H), req: req});
    end
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_chk++;
      if (cpu_rst_n !== it.exp) begin
        n_bad++;
        $display("FAIL %s: cpu_rst_n=%b expected %b at %0t", it.req, cpu_rst_n, it.exp, $time);
      end
    end
  end

  initial begin
    m_q = 0;
    drive(1, 0, 1, 0, "R1", 3);
    drive(0, 0, 1, 0, "R1", H + 4);
    drive(0, 1, 1, 0, "R2", 5);
    drive(0, 0, 1, 0, "R3", H + 4);
    drive(0, 1, 1, 0, "R4", 2);
    drive(0, 0, 1, 0, "R4", 4);
    drive(0, 1, 1, 0, "R4", 2);
    drive(0, 0, 1, 0, "R4", H + 4);
    drive(0, 0, 0, 0, "R5", 3);
    drive(0, 0, 1, 0, "R5", H + 6);
    drive(0, 0, 0, 0, "R8", 1);
    drive(0, 0, 1, 0, "R8", 2);
    drive(0, 0, 0, 0, "R8", 1);
    drive(0, 0, 1, 0, "R8", 1);
    drive(0, 0, 0, 0, "R8", 2);
    drive(0, 0, 1, 0, "R8", H + 6);
    drive(0, 0, 1, 1, "R6", 3);
    drive(0, 0, 0, 1, "R7", 2);
    drive(0, 0, 1, 1, "R7", 3);
    drive(0, 0, 1, 0, "R7", H + 4);
    drive(0, 0, 1, 0, "R9", 40);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule